// File: doc/BRIEF.md
# Descending Byte Run Checker

This block watches a byte-wide stream that delivers one byte per clock and judges framed groups of eight consecutive bytes. A start pulse marks the first byte of a group, and the next seven bytes follow on the next seven clocks. The check passes only if each byte is exactly one below the byte before it. One cycle after the eighth byte has been sampled, a single-cycle done pulse appears. The pass or fail verdict is shown on a second flag in that same cycle.

The block does not store the bytes. It keeps only the previous byte, a position counter and a sticky mismatch flag. A new start pulse always wins. It abandons any group in progress and begins a fresh group with the current byte. This means groups can follow each other with no idle cycle between them. Bytes that arrive outside a group have no effect.

Top module: `desc_run_check`

## Requirements
- R1: A synchronous reset clears the group in progress and both outputs. After reset the block is idle, and bytes sent without a new start pulse never produce a done pulse.
- R2: done is high for exactly one cycle. That cycle is the one right after the eighth byte of a group is sampled, eight clocks after the start edge. done is low during the eight byte cycles.
- R3: When done is high, in_seq is high if each of bytes 2 to 8 equals the byte before it minus one.
- R4: When done is high, in_seq is low if a step fails at any position from 2 to 8, including a step at the first position and at the last position.
- R5: The step is plain unsigned arithmetic with no wraparound. 0x01 followed by 0x00 is a valid step. 0x00 followed by 0xFF is a mismatch.
- R6: in_seq is never high in a cycle where done is low.
- R7: A start pulse during a group discards that group. Its bytes and any mismatch it held are dropped, and the new group's done arrives eight clocks after the new start.
- R8: Bytes sampled with start low and no group in progress are ignored, and done stays low.
- R9: A start pulse in the same cycle as done begins a new group at once, and that group's done arrives eight clocks later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| din | input | DATA_W (8) | Byte sampled on each clock |
| start | input | 1 | Marks din as the first byte of a new group |
| done | output | 1 | One-cycle pulse after the last byte of a group |
| in_seq | output | 1 | Verdict for the group, valid while done is high |

## Verification
Reporting a finished group and starting the next can happen in the same cycle. The bench provokes this by raising start, with the first byte of a second group, in exactly the cycle where done for the first group is high. It checks two things. The first verdict must be correct, and the second group's done must arrive exactly eight clocks later with its own verdict. The first group's verdict must not leak into the second group's mismatch state. The bench also places a restart part-way into a failing group and checks that no pulse appears at the old group's slot.

// File: rtl/desc_run_pkg.sv
package desc_run_pkg;
  typedef enum logic {
    FR_IDLE = 1'b0,
    FR_BUSY = 1'b1
  } frame_state_t;
endpackage

// File: rtl/drc_framer.sv
module drc_framer
  import desc_run_pkg::*;
#(
  parameter int GROUP_LEN = 8,
  localparam int CNT_W = $clog2(GROUP_LEN)
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic take_first,
  output logic take_next,
  output logic last,
  output logic busy
);
  localparam logic [CNT_W-1:0] LAST_POS = CNT_W'(GROUP_LEN - 1);

  frame_state_t state;
  logic [CNT_W-1:0] pos;

  assign busy       = (state == FR_BUSY);
  assign take_first = start;
  assign take_next  = busy && !start;
  assign last       = take_next && (pos == LAST_POS);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= FR_IDLE;
      pos   <= '0;
    end else if (start) begin
      state <= FR_BUSY;
      pos   <= CNT_W'(1);
    end else if (busy) begin
      if (pos == LAST_POS) begin
        state <= FR_IDLE;
        pos   <= '0;
      end else begin
        pos <= pos + CNT_W'(1);
      end
    end
  end

  // R7
  busy_entry_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(start));

  // R1
  reset_idle_chk: assert property (@(posedge clk)
    $past(rst) && !rst |-> !busy);
endmodule

// File: rtl/drc_step_cmp.sv
module drc_step_cmp #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [DATA_W-1:0] din,
  output logic              step_bad
);
  logic [DATA_W-1:0] prev;

  // no wraparound: a zero predecessor can never be stepped below
  assign step_bad = (prev == '0) || (din != prev - DATA_W'(1));

  always_ff @(posedge clk) begin
    if (rst)       prev <= '0;
    else if (load) prev <= din;
  end
endmodule

// File: rtl/drc_verdict.sv
module drc_verdict (
  input  logic clk,
  input  logic rst,
  input  logic take_first,
  input  logic take_next,
  input  logic last,
  input  logic step_bad,
  output logic done,
  output logic in_seq
);
  logic miss;

  always_ff @(posedge clk) begin
    if (rst) begin
      miss   <= 1'b0;
      done   <= 1'b0;
      in_seq <= 1'b0;
    end else begin
      if (take_first)     miss <= 1'b0;
      else if (take_next) miss <= miss | step_bad;
      done   <= last;
      in_seq <= last && !(miss || step_bad);
    end
  end

  // R6
  seq_needs_done_chk: assert property (@(posedge clk) disable iff (rst)
    in_seq |-> done);

  // R2
  single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R4
  miss_blocks_pass_chk: assert property (@(posedge clk) disable iff (rst)
    last && miss && !take_first |=> done && !in_seq);
endmodule

// File: rtl/desc_run_check.sv
module desc_run_check #(
  parameter int DATA_W    = 8,
  parameter int GROUP_LEN = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] din,
  input  logic              start,
  output logic              done,
  output logic              in_seq
);
  localparam int AGE_W = $clog2(GROUP_LEN + 1);

  logic take_first, take_next, last, busy, step_bad;

  drc_framer #(.GROUP_LEN(GROUP_LEN)) u_framer (
    .clk(clk), .rst(rst), .start(start),
    .take_first(take_first), .take_next(take_next),
    .last(last), .busy(busy)
  );

  drc_step_cmp #(.DATA_W(DATA_W)) u_cmp (
    .clk(clk), .rst(rst), .load(take_first | take_next),
    .din(din), .step_bad(step_bad)
  );

  drc_verdict u_verdict (
    .clk(clk), .rst(rst), .take_first(take_first),
    .take_next(take_next), .last(last), .step_bad(step_bad),
    .done(done), .in_seq(in_seq)
  );

  // checker-side count of clocks since the latest start
  logic [AGE_W-1:0] age;
  logic             age_ok;
  always_ff @(posedge clk) begin
    if (rst) begin
      age    <= '0;
      age_ok <= 1'b0;
    end else if (start) begin
      age    <= AGE_W'(1);
      age_ok <= 1'b1;
    end else if (age_ok && age != AGE_W'(GROUP_LEN)) begin
      age <= age + AGE_W'(1);
    end else begin
      age_ok <= 1'b0;
    end
  end

  // R2
  done_timing_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> age_ok && age == AGE_W'(GROUP_LEN));

  // R8
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !busy && !start |=> !done);
endmodule

// File: tb/desc_run_check_test.sv
module desc_run_check_test;
  logic       clk = 1'b0;
  logic       rst;
  logic [7:0] din;
  logic       start;
  logic       done, in_seq;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  desc_run_check uut (
    .clk(clk), .rst(rst), .din(din), .start(start),
    .done(done), .in_seq(in_seq)
  );

  // {byte1 .. byte8, expected in_seq}
  localparam logic [64:0] VEC [10] = '{
    {64'h8786858483828180, 1'b1},
    {64'h0706050403020100, 1'b1},
    {64'hFFFEFDFCFBFAF9F8, 1'b1},
    {64'h0100FFFEFDFCFBFA, 1'b0},
    {64'h100F0E0D0C0B0A0A, 1'b0},
    {64'h10100F0E0D0C0B0A, 1'b0},
    {64'h807F7E7F7C7B7A79, 1'b0},
    {64'h0001020304050607, 1'b0},
    {64'h5555555555555555, 1'b0},
    {64'h201E1D1C1B1A1918, 1'b0}
  };

  task automatic check(input logic act, input logic exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic tick(input logic [7:0] b, input logic s);
    @(negedge clk);
    din   = b;
    start = s;
  endtask

  // drives the eight bytes; done must stay low on bytes 2..8 (R2)
  task automatic send_group(input logic [63:0] g);
    tick(g[63:56], 1'b1);
    for (int i = 1; i < 8; i++) begin
      tick(g[63-8*i -: 8], 1'b0);
      check(done, 1'b0, "R2 done low inside group");
      check(in_seq, 1'b0, "R6 in_seq low without done");
    end
  endtask

  initial begin
    #(8 * 150000);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst = 1'b1; din = 8'h00; start = 1'b0;
    repeat (3) @(negedge clk);
    check(done, 1'b0, "R1 done after reset");
    check(in_seq, 1'b0, "R1 in_seq after reset");
    rst = 1'b0;

    // table walk: R3, R4, R5
    for (int v = 0; v < 10; v++) begin
      send_group(VEC[v][64:1]);
      tick(8'h00, 1'b0);
      check(done, 1'b1, "R2 done after byte 8");
      check(in_seq, VEC[v][0], VEC[v][0] ? "R3 pass verdict" : "R4/R5 fail verdict");
      tick(8'h00, 1'b0);
      check(done, 1'b0, "R2 done one cycle only");
    end

    // R8: loose bytes with no group open
    for (int i = 0; i < 12; i++) begin
      tick(8'h40 - 8'(i), 1'b0);
      check(done, 1'b0, "R8 idle bytes ignored");
    end

    // R7: failing group restarted part-way, then a good group
    tick(8'h00, 1'b1);
    tick(8'h55, 1'b0);
    tick(8'h33, 1'b0);
    tick(8'h90, 1'b0);
    send_group(64'h4948474645444342);   // old slot falls inside this group
    tick(8'h00, 1'b0);
    check(done, 1'b1, "R7 done 8 clocks after restart");
    check(in_seq, 1'b1, "R7 stale mismatch dropped");

    // R9: back to back, next start in the done cycle
    send_group(64'h3332313030302F2E);
    tick(8'hC8, 1'b1);
    check(done, 1'b1, "R9 first done");
    check(in_seq, 1'b0, "R9 first verdict");
    for (int i = 1; i < 8; i++) begin
      tick(8'hC8 - 8'(i), 1'b0);
      check(done, 1'b0, "R9 second group running");
    end
    tick(8'h00, 1'b0);
    check(done, 1'b1, "R9 second done");
    check(in_seq, 1'b1, "R9 second verdict");

    // R1: reset mid-group, then bytes with no start
    tick(8'h70, 1'b1);
    tick(8'h6F, 1'b0);
    tick(8'h6E, 1'b0);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    for (int i = 0; i < 10; i++) begin
      tick(8'h6D - 8'(i), 1'b0);
      check(done, 1'b0, "R1 reset abandons group");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule